// File: doc/BRIEF.md
# Complementary PWM Dead-Time Generator

This block turns each of several PWM reference signals into a pair of complementary drive outputs, a main (high-side) output and a complementary (low-side) output. Whenever a reference changes level, the output that must turn off does so at once. The output that must turn on waits out a programmable dead time first. As a result the two outputs of a pair are never active in the same cycle, which protects a half-bridge from shoot-through.

The dead time comes from one 8-bit code shared by every pair. The code is decoded nonlinearly: a short code prefix picks one of four segments, with step sizes of 1, 2, 8 and 16 ticks, so 8 bits reach up to 1008 ticks. With the default `TICK_DIV2 = 0` a tick is one clock cycle. With `TICK_DIV2 = 1` the count advances every other cycle, as it does when the timer runs from a divided bus clock. Each pair captures the decoded value at the reference edge that starts an interval. A code change therefore only affects later edges.

Top module: `cpwm_deadband`

## Requirements
- R1: The main and complementary outputs of a pair are never both 1 in the same cycle.
- R2: When a pair's reference is first sampled high, its complementary output is 0 after that same clock edge. Its main output goes to 1 exactly N clock edges later, where N is the decoded dead time; with N = 0 it goes to 1 on the same edge.
- R3: When a pair's reference is first sampled low, its main output is 0 after that same clock edge. Its complementary output goes to 1 exactly N clock edges later, or on the same edge if N = 0.
- R4: A code with bit 7 = 0 decodes to N = code[6:0] (0 to 127).
- R5: A code with bits [7:6] = 2'b10 decodes to N = 2 × (64 + code[5:0]) (128 to 254).
- R6: A code with bits [7:5] = 3'b110 decodes to N = 8 × (32 + code[4:0]) (256 to 504).
- R7: A code with bits [7:5] = 3'b111 decodes to N = 16 × (32 + code[4:0]) (512 to 1008).
- R8: If the reference returns to its previous level before the dead time ends, the delayed output stays 0 for the whole pulse. The dead time then restarts for the opposite output.
- R9: A clock edge that samples out_en low drives every output to 0 and clears the pending count. On the first edge that samples out_en high again, the output selected by the reference starts a full dead time before it becomes active.
- R10: The dead time is taken from the code sampled at the edge that starts the interval. Changing the code during an interval does not alter that interval.
- R11: All pairs share one code, but each pair times its own edges independently of the others.
- R12: While rst is high, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | NUM_PAIRS | PWM reference, one bit per pair |
| dt_code | input | 8 | Shared nonlinear dead-time code |
| out_en | input | 1 | Output enable; low forces all outputs to 0 |
| main_out | output | NUM_PAIRS | Main (non-inverted) outputs |
| comp_out | output | NUM_PAIRS | Complementary (inverted) outputs |

## Verification
The bench measures the gap at the low and high end of each decode segment (127/128, 254/256, 504/512, 1008). A decoder that drops or misplaces a segment offset shows up there as a gap that is off by a fixed step. It sends a reference pulse shorter than the dead time; a design that kept counting across the edge would briefly turn the delayed output on. It changes the code partway through an interval, where a design that reloads continuously would end early. It also toggles the enable, and a design that resumed without a fresh dead time would turn an output on at once. Random reference, code and enable traffic on two pairs is compared every cycle against a model built from R2, R3 and R9.

// File: rtl/cpwm_deadband_pkg.sv
package cpwm_deadband_pkg;

    localparam int CODE_W = 8;
    localparam int DT_W   = 10;

    typedef logic [CODE_W-1:0] dt_code_t;
    typedef logic [DT_W-1:0]   dt_ticks_t;

    typedef struct packed {
        logic main;
        logic comp;
    } drv_pair_t;

    typedef struct packed {
        logic      armed;
        logic      ref_q;
        dt_ticks_t cnt;
        drv_pair_t drv;
    } pair_state_t;

    // Prefix-selected segments: steps of 1, 2, 8 and 16 ticks.
    function automatic dt_ticks_t dt_decode(input dt_code_t c);
        dt_ticks_t base;
        if (!c[7]) begin
            dt_decode = {3'b000, c[6:0]};
        end else if (!c[6]) begin
            base = {4'b0000, c[5:0]} + dt_ticks_t'(64);
            dt_decode = base << 1;
        end else if (!c[5]) begin
            base = {5'b00000, c[4:0]} + dt_ticks_t'(32);
            dt_decode = base << 3;
        end else begin
            base = {5'b00000, c[4:0]} + dt_ticks_t'(32);
            dt_decode = base << 4;
        end
    endfunction

    function automatic drv_pair_t level_drive(input logic lvl);
        drv_pair_t d;
        d.main = lvl;
        d.comp = ~lvl;
        return d;
    endfunction

endpackage

// File: rtl/cpwm_dt_decode.sv
module cpwm_dt_decode
    import cpwm_deadband_pkg::*;
(
    input  dt_code_t  code,
    output dt_ticks_t ticks
);
    assign ticks = dt_decode(code);
endmodule

// File: rtl/cpwm_tick_gen.sv
module cpwm_tick_gen #(
    parameter int TICK_DIV2 = 0
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam logic DIV_ON = (TICK_DIV2 != 0);

    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= DIV_ON ? ~phase_q : 1'b0;
        end
    end

    assign tick = phase_q | ~DIV_ON;
endmodule

// File: rtl/cpwm_pair_ctrl.sv
module cpwm_pair_ctrl
    import cpwm_deadband_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      out_en,
    input  logic      ref_in,
    input  dt_ticks_t dt_load,
    output drv_pair_t drv
);
    pair_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!out_en) begin
            st_d.armed = 1'b0;
            st_d.ref_q = ref_in;
            st_d.cnt   = '0;
            st_d.drv   = '0;
        end else if (!st_q.armed || (ref_in != st_q.ref_q)) begin
            // Edge (or restart after disable): capture dead time now.
            st_d.armed = 1'b1;
            st_d.ref_q = ref_in;
            st_d.cnt   = dt_load;
            if (dt_load == '0) begin
                st_d.drv = level_drive(ref_in);
            end else begin
                st_d.drv = '0;
            end
        end else if (st_q.cnt != '0) begin
            if (tick) begin
                st_d.cnt = st_q.cnt - dt_ticks_t'(1);
                if (st_q.cnt == dt_ticks_t'(1)) begin
                    st_d.drv = level_drive(st_q.ref_q);
                end
            end
        end else begin
            st_d.drv = level_drive(st_q.ref_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drv = st_q.drv;
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband
    import cpwm_deadband_pkg::*;
#(
    parameter int NUM_PAIRS = 2,
    parameter int TICK_DIV2 = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PAIRS-1:0] ref_in,
    input  logic [7:0]           dt_code,
    input  logic                 out_en,
    output logic [NUM_PAIRS-1:0] main_out,
    output logic [NUM_PAIRS-1:0] comp_out
);
    dt_ticks_t dt_ticks;
    logic      tick;

    cpwm_dt_decode u_decode (
        .code  (dt_code),
        .ticks (dt_ticks)
    );

    cpwm_tick_gen #(.TICK_DIV2(TICK_DIV2)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        drv_pair_t drv;

        cpwm_pair_ctrl u_ctrl (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .out_en  (out_en),
            .ref_in  (ref_in[g]),
            .dt_load (dt_ticks),
            .drv     (drv)
        );

        assign main_out[g] = drv.main;
        assign comp_out[g] = drv.comp;
    end
endmodule

// File: rtl/cpwm_deadband_chk.sv
module cpwm_deadband_chk #(
    parameter int NUM_PAIRS = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 out_en,
    input logic [NUM_PAIRS-1:0] ref_in,
    input logic [NUM_PAIRS-1:0] main_out,
    input logic [NUM_PAIRS-1:0] comp_out
);
    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_chk
        assert_no_overlap_R1: assert property (@(posedge clk) disable iff (rst)
            !(main_out[g] && comp_out[g]));

        assert_main_rise_R2: assert property (@(posedge clk) disable iff (rst)
            $rose(main_out[g]) |-> ($past(ref_in[g]) && $past(out_en)));

        assert_comp_rise_R3: assert property (@(posedge clk) disable iff (rst)
            $rose(comp_out[g]) |-> (!$past(ref_in[g]) && $past(out_en)));
    end

    assert_disable_R9: assert property (@(posedge clk) disable iff (rst)
        !out_en |=> ((main_out == '0) && (comp_out == '0)));
endmodule

bind cpwm_deadband cpwm_deadband_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .out_en   (out_en),
    .ref_in   (ref_in),
    .main_out (main_out),
    .comp_out (comp_out)
);

// File: tb/cpwm_deadband_bench.sv
module cpwm_deadband_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] ref_in = '0;
    logic [7:0]    dt_code = 8'd0;
    logic          out_en = 1'b0;
    logic [NP-1:0] main_out;
    logic [NP-1:0] comp_out;

    int  checks = 0;
    int  failures = 0;
    bit  cmp_on = 1'b0;
    bit  done = 1'b0;

    int  m_s [NP];
    int  m_n [NP];
    bit  m_ref [NP];
    bit  m_live [NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    cpwm_deadband #(.NUM_PAIRS(NP)) u_cpwm_deadband (
        .clk      (clk),
        .rst      (rst),
        .ref_in   (ref_in),
        .dt_code  (dt_code),
        .out_en   (out_en),
        .main_out (main_out),
        .comp_out (comp_out)
    );

    // Expected tick count from the segment arithmetic in R4..R7.
    function automatic int exp_dt(input int code);
        if (code < 128)      return code;
        else if (code < 192) return 2 * (code - 64);
        else if (code < 224) return 8 * (code - 160);
        else                 return 16 * (code - 192);
    endfunction

    function automatic string seg_tag(input int code);
        if (code < 128)      return "R4";
        else if (code < 192) return "R5";
        else if (code < 224) return "R6";
        else                 return "R7";
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model from R2/R3/R9/R10: cycles since edge vs captured N.
    always @(posedge clk) begin
        for (int p = 0; p < NP; p++) begin
            if (rst || !out_en) begin
                m_s[p] = 0;
                m_live[p] = 1'b0;
                m_ref[p] = ref_in[p];
            end else if (!m_live[p] || (ref_in[p] != m_ref[p])) begin
                m_s[p] = 1;
                m_n[p] = exp_dt(int'(dt_code));
                m_live[p] = 1'b1;
                m_ref[p] = ref_in[p];
            end else if (m_s[p] < 5000) begin
                m_s[p] = m_s[p] + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            for (int p = 0; p < NP; p++) begin
                bit em, ec;
                em = m_ref[p] && (m_s[p] > m_n[p]);
                ec = !m_ref[p] && (m_s[p] > m_n[p]);
                check(main_out[p] == em, "R2 model main", int'(main_out[p]), int'(em));
                check(comp_out[p] == ec, "R3 model comp", int'(comp_out[p]), int'(ec));
                check(!(main_out[p] && comp_out[p]), "R1 overlap",
                      int'(main_out[p] & comp_out[p]), 0);
            end
        end
    end

    // Counts negedges until the chosen output of pair p turns on.
    task automatic measure(input int p, input bit want_main, input int exp, input string tag);
        int  k;
        bit  hit;
        k = 0;
        hit = 1'b0;
        for (int i = 0; i < 1100; i++) begin
            @(negedge clk);
            if (i == 0) begin
                check((want_main ? comp_out[p] : main_out[p]) == 1'b0,
                      {tag, " opposite off at once"},
                      int'(want_main ? comp_out[p] : main_out[p]), 0);
            end
            if (want_main ? main_out[p] : comp_out[p]) begin
                hit = 1'b1;
                break;
            end
            k++;
        end
        check(hit && (k == exp), tag, k, exp);
    endtask

    initial begin
        int codes [9] = '{8'h00, 8'h05, 8'h7F, 8'h80, 8'hBF, 8'hC0, 8'hDF, 8'hE0, 8'hFF};
        void'($urandom(32'd2718));

        repeat (3) @(negedge clk);
        check(main_out == '0 && comp_out == '0, "R12 reset", int'({main_out, comp_out}), 0);
        rst = 1'b0;
        cmp_on = 1'b1;

        // R9: enable with ref low -> comp waits full dead time
        dt_code = 8'd5;
        @(negedge clk);
        out_en = 1'b1;
        measure(0, 1'b0, 5, "R9 re-enable");

        // R2/R3 with R4..R7 segment boundaries
        foreach (codes[j]) begin
            dt_code = codes[j][7:0];
            @(negedge clk);
            ref_in[0] = 1'b1;
            measure(0, 1'b1, exp_dt(codes[j]), {"R2 ", seg_tag(codes[j])});
            @(negedge clk);
            ref_in[0] = 1'b0;
            measure(0, 1'b0, exp_dt(codes[j]), {"R3 ", seg_tag(codes[j])});
        end

        // R8: pulse shorter than dead time
        dt_code = 8'd30;
        @(negedge clk);
        ref_in[0] = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(main_out[0] == 1'b0, "R8 short pulse main stays off", int'(main_out[0]), 0);
        end
        ref_in[0] = 1'b0;
        measure(0, 1'b0, 30, "R8 comp after short pulse");

        // R10: code change mid-interval does not alter it
        dt_code = 8'd40;
        @(negedge clk);
        ref_in[0] = 1'b1;
        begin
            int k;
            k = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (i == 10) dt_code = 8'd2;
                if (main_out[0]) break;
                k++;
            end
            check(k == 40, "R10 code change mid-interval", k, 40);
        end

        // R11: pair 1 uses the same shared code, pair 0 undisturbed
        dt_code = 8'h82;
        @(negedge clk);
        ref_in[1] = 1'b1;
        measure(1, 1'b1, 132, "R11 pair1 shared code");
        check(main_out[0] == 1'b1, "R11 pair0 undisturbed", int'(main_out[0]), 1);

        // R9: disable forces outputs off at next edge
        @(negedge clk);
        out_en = 1'b0;
        @(negedge clk);
        check(main_out == '0 && comp_out == '0, "R9 disable", int'({main_out, comp_out}), 0);
        ref_in = 2'b01;
        repeat (3) @(negedge clk);
        check(main_out == '0 && comp_out == '0, "R9 held off", int'({main_out, comp_out}), 0);
        dt_code = 8'd9;
        out_en = 1'b1;
        measure(0, 1'b1, 9, "R9 re-enable main");

        // Random traffic compared by the model
        for (int cyc = 0; cyc < 6000; cyc++) begin
            @(negedge clk);
            for (int p = 0; p < NP; p++) begin
                if ($urandom % 24 == 0) ref_in[p] = ~ref_in[p];
            end
            if ($urandom % 60 == 0) begin
                int r;
                r = int'($urandom % 16);
                if (r < 12)      dt_code = 8'($urandom % 40);
                else if (r < 15) dt_code = 8'h80 | 8'($urandom % 4);
                else             dt_code = 8'hC0;
            end
            out_en = ($urandom % 250) != 0;
        end

        repeat (3) @(negedge clk);
        cmp_on = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule